// File: doc/BRIEF.md
# Battery Charger Mode Supervisor

This block is the digital supervisor of a notebook battery charger. On every strobe of a sample enable it takes four digitized measurements: adapter-detect voltage, internal supply voltage, battery voltage and die temperature. From these and its own stored settings it decides whether the converter may run, whether charging is allowed, whether the adapter path is connected, and whether the pack is charged in trickle mode or in fast mode. It also produces the charge-current target that the analog current loop follows.

The settings are kept in four small registers written through a single-beat write port: the programmed charge current, the minimum system voltage, the maximum system voltage and an isolate-adapter bit. The power-up default of the maximum system voltage is fixed at build time by the number of series cells. Adapter detection and die temperature each pass through a two-threshold latch. The trickle/fast decision must persist for a set number of consecutive samples before it takes effect. Every output is registered and updates at the clock edge that captures the sample or the write.

Top module: `chg_mode_sup`

## Requirements
- R1: A synchronous active-high reset clears `adp_prsnt`, `adp_sel`, `conv_en`, `chg_en`, `trk_stat`, `iso_reg`, `ichg_reg` and `chg_tgt_ma` to 0, sets `trk_n` to 1 and sets `mode` to OFF (2'd0).
- R2: At a sample, `adp_prsnt` becomes 1 when `adp_mv` is above ADP_RISE_MV (3200), becomes 0 when it is below ADP_RISE_MV-ADP_HYST_MV (3143), and otherwise keeps its value. Values of exactly 3200 or 3143 hold.
- R3: `adp_sel` is 1 exactly when `adp_prsnt` is 1, the most recently sampled `sup_mv` was above SUP_MIN_MV (4500) and `iso_reg` is 0. A write of the isolate bit takes effect on `adp_sel` at the same edge.
- R4: At a sample, the over-temperature state sets when `die_degc` is above 150 and clears when it is below 125; between the two it holds. While it is set, `conv_en` is 0.
- R5: `conv_en` equals `adp_prsnt` AND NOT over-temperature. `chg_en` equals `conv_en` AND a nonzero `ichg_reg`.
- R6: The trickle state changes only after FILT_LEN consecutive samples that all disagree with it. Trickle is wanted when `bat_mv` is below the stored minimum system voltage, which includes 0 mV. A sample that agrees with the current state restarts the count.
- R7: In trickle, `chg_tgt_ma` is TRK_MA (256) while `ichg_reg` keeps its programmed value. Out of trickle, `chg_tgt_ma` equals `ichg_reg`.
- R8: `trk_stat` is 1 and `trk_n` is 0 in trickle, and the reverse in fast mode. `mode` is OFF (0) when `conv_en` is 0, otherwise TRICKLE (1) or FAST (2).
- R9: `vmax_reg` resets to CELLS x 4200 mV (8400 for 2 cells, 12600 for 3 cells).
- R10: When `wr_en` is high, `wr_sel` picks the register that `wr_data` is written into: 0 for charge current, 1 for minimum system voltage, 2 for maximum system voltage, 3 for the isolate bit (`wr_data[0]`).
- R11: While `smp_en` is 0, changes on the measurement inputs leave every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_en | input | 1 | Measurement sample strobe |
| adp_mv | input | MV_W | Adapter-detect voltage, mV |
| sup_mv | input | MV_W | Internal supply voltage, mV |
| bat_mv | input | MV_W | Battery voltage, mV |
| die_degc | input | T_W | Die temperature, degrees C |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for the write |
| wr_data | input | MV_W | Write data |
| adp_prsnt | output | 1 | Adapter present (0 = pulled low) |
| adp_sel | output | 1 | Adapter path select, active high |
| conv_en | output | 1 | Converter enable |
| chg_en | output | 1 | Charge enable |
| trk_stat | output | 1 | Trickle status bit |
| trk_n | output | 1 | Trickle indication, active low |
| mode | output | 2 | 0 OFF, 1 TRICKLE, 2 FAST |
| chg_tgt_ma | output | MV_W | Effective charge-current target, mA |
| ichg_reg | output | MV_W | Stored charge-current setting |
| vmax_reg | output | MV_W | Stored maximum system voltage |
| iso_reg | output | 1 | Stored isolate-adapter bit |

## Verification
The hardest state to reach is a trickle/fast transition that is held back by a run of disagreeing samples broken off one sample short. Wrong filtering can only be seen after a pattern that alternates across the minimum voltage. The bench drives a long pseudo-random walk of battery values within a few millivolts of the programmed minimum, mixed with idle cycles and 0 mV samples. This produces many runs that are cut short and many that complete. The two hysteresis latches are swept one millivolt or one degree at a time, up and then down across both thresholds, so that every hold band and every exact threshold value is visited from both sides.

// File: rtl/chg_sup_pkg.sv
package chg_sup_pkg;
    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_TRK  = 2'd1,
        MODE_FAST = 2'd2
    } chg_mode_e;

    localparam logic [1:0] SEL_ICHG = 2'd0;
    localparam logic [1:0] SEL_VMIN = 2'd1;
    localparam logic [1:0] SEL_VMAX = 2'd2;
    localparam logic [1:0] SEL_ISO  = 2'd3;
endpackage

// File: rtl/chg_sup_hyst.sv
module chg_sup_hyst #(
    parameter int unsigned   W  = 16,
    parameter logic [W-1:0]  HI = '1,
    parameter logic [W-1:0]  LO = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] val,
    output logic         lvl_d,
    output logic         lvl_q
);
    always_comb begin
        lvl_d = lvl_q;
        if (en) begin
            if (val > HI)      lvl_d = 1'b1;
            else if (val < LO) lvl_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b0;
        else     lvl_q <= lvl_d;
    end

    // R2 (adapter instance) and R4 (thermal instance)
    assert_hyst_set_R2_R4: assert property (@(posedge clk) disable iff (rst)
        (en && val > HI) |=> lvl_q);
    assert_hyst_clr_R2_R4: assert property (@(posedge clk) disable iff (rst)
        (en && val < LO) |=> !lvl_q);
    assert_hyst_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(lvl_q));
endmodule

// File: rtl/chg_sup_filt.sv
module chg_sup_filt #(
    parameter int unsigned LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic raw,
    output logic out_d,
    output logic out_q
);
    localparam int unsigned    CW   = $clog2(LEN + 1);
    localparam logic [CW-1:0]  LAST = CW'(LEN - 1);

    typedef struct packed {
        logic          out;
        logic [CW-1:0] cnt;
    } filt_st_t;

    filt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en) begin
            if (raw != st_q.out) begin
                if (st_q.cnt == LAST) begin
                    st_d.out = raw;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end else begin
                st_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_d = st_d.out;
    assign out_q = st_q.out;

    assert_filt_cnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= LAST);
    assert_filt_follow_R6: assert property (@(posedge clk) disable iff (rst)
        (out_q != $past(out_q)) |-> ($past(en) && out_q == $past(raw)));
    assert_filt_agree_R6: assert property (@(posedge clk) disable iff (rst)
        (en && raw == out_q) |=> $stable(out_q));
    assert_filt_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(out_q));
endmodule

// File: rtl/chg_mode_sup.sv
module chg_mode_sup
    import chg_sup_pkg::*;
#(
    parameter int unsigned MV_W         = 16,
    parameter int unsigned T_W          = 8,
    parameter int unsigned CELLS        = 2,
    parameter int unsigned FILT_LEN     = 4,
    parameter int unsigned ADP_RISE_MV  = 3200,
    parameter int unsigned ADP_HYST_MV  = 57,
    parameter int unsigned SUP_MIN_MV   = 4500,
    parameter int unsigned HOT_SET_C    = 150,
    parameter int unsigned HOT_CLR_C    = 125,
    parameter int unsigned TRK_MA       = 256,
    parameter int unsigned CELL_VMAX_MV = 4200,
    parameter int unsigned CELL_VMIN_MV = 3000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            smp_en,
    input  logic [MV_W-1:0] adp_mv,
    input  logic [MV_W-1:0] sup_mv,
    input  logic [MV_W-1:0] bat_mv,
    input  logic [T_W-1:0]  die_degc,
    input  logic            wr_en,
    input  logic [1:0]      wr_sel,
    input  logic [MV_W-1:0] wr_data,
    output logic            adp_prsnt,
    output logic            adp_sel,
    output logic            conv_en,
    output logic            chg_en,
    output logic            trk_stat,
    output logic            trk_n,
    output logic [1:0]      mode,
    output logic [MV_W-1:0] chg_tgt_ma,
    output logic [MV_W-1:0] ichg_reg,
    output logic [MV_W-1:0] vmax_reg,
    output logic            iso_reg
);
    localparam logic [MV_W-1:0] ADP_HI   = MV_W'(ADP_RISE_MV);
    localparam logic [MV_W-1:0] ADP_LO   = MV_W'(ADP_RISE_MV - ADP_HYST_MV);
    localparam logic [MV_W-1:0] SUP_MIN  = MV_W'(SUP_MIN_MV);
    localparam logic [T_W-1:0]  HOT_HI   = T_W'(HOT_SET_C);
    localparam logic [T_W-1:0]  HOT_LO   = T_W'(HOT_CLR_C);
    localparam logic [MV_W-1:0] TRK_TGT  = MV_W'(TRK_MA);
    localparam logic [MV_W-1:0] VMAX_DEF = MV_W'(CELLS * CELL_VMAX_MV);
    localparam logic [MV_W-1:0] VMIN_DEF = MV_W'(CELLS * CELL_VMIN_MV);

    typedef struct packed {
        logic            sup_ok;
        logic            adp_sel;
        logic            conv_en;
        logic            chg_en;
        chg_mode_e       mode;
        logic [MV_W-1:0] tgt;
        logic [MV_W-1:0] ichg;
        logic [MV_W-1:0] vmin;
        logic [MV_W-1:0] vmax;
        logic            iso;
    } sup_st_t;

    localparam sup_st_t ST_RST = '{
        sup_ok:  1'b0, adp_sel: 1'b0, conv_en: 1'b0, chg_en: 1'b0,
        mode:    MODE_OFF, tgt: '0, ichg: '0,
        vmin:    VMIN_DEF, vmax: VMAX_DEF, iso: 1'b0
    };

    sup_st_t st_d, st_q;
    logic    adp_d, adp_q;
    logic    hot_d, hot_q;
    logic    trk_d, trk_q;

    chg_sup_hyst #(.W(MV_W), .HI(ADP_HI), .LO(ADP_LO)) adp_hyst_i (
        .clk(clk), .rst(rst), .en(smp_en), .val(adp_mv),
        .lvl_d(adp_d), .lvl_q(adp_q)
    );

    chg_sup_hyst #(.W(T_W), .HI(HOT_HI), .LO(HOT_LO)) hot_hyst_i (
        .clk(clk), .rst(rst), .en(smp_en), .val(die_degc),
        .lvl_d(hot_d), .lvl_q(hot_q)
    );

    chg_sup_filt #(.LEN(FILT_LEN)) trk_filt_i (
        .clk(clk), .rst(rst), .en(smp_en), .raw(bat_mv < st_q.vmin),
        .out_d(trk_d), .out_q(trk_q)
    );

    always_comb begin
        st_d = st_q;
        if (smp_en) st_d.sup_ok = (sup_mv > SUP_MIN);
        if (wr_en) begin
            case (wr_sel)
                SEL_ICHG: st_d.ichg = wr_data;
                SEL_VMIN: st_d.vmin = wr_data;
                SEL_VMAX: st_d.vmax = wr_data;
                default:  st_d.iso  = wr_data[0];
            endcase
        end
        st_d.adp_sel = adp_d & st_d.sup_ok & ~st_d.iso;
        st_d.conv_en = adp_d & ~hot_d;
        st_d.chg_en  = st_d.conv_en & (st_d.ichg != '0);
        if (!st_d.conv_en) st_d.mode = MODE_OFF;
        else if (trk_d)    st_d.mode = MODE_TRK;
        else               st_d.mode = MODE_FAST;
        st_d.tgt = trk_d ? TRK_TGT : st_d.ichg;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_RST;
        else     st_q <= st_d;
    end

    assign adp_prsnt  = adp_q;
    assign adp_sel    = st_q.adp_sel;
    assign conv_en    = st_q.conv_en;
    assign chg_en     = st_q.chg_en;
    assign trk_stat   = trk_q;
    assign trk_n      = ~trk_q;
    assign mode       = st_q.mode;
    assign chg_tgt_ma = st_q.tgt;
    assign ichg_reg   = st_q.ichg;
    assign vmax_reg   = st_q.vmax;
    assign iso_reg    = st_q.iso;

    assert_sel_gate_R3: assert property (@(posedge clk) disable iff (rst)
        adp_sel |-> (adp_prsnt && !iso_reg));
    assert_hot_off_R4: assert property (@(posedge clk) disable iff (rst)
        (smp_en && die_degc > HOT_HI) |=> !conv_en);
    assert_conv_adp_R5: assert property (@(posedge clk) disable iff (rst)
        conv_en |-> adp_prsnt);
    assert_chg_conv_R5: assert property (@(posedge clk) disable iff (rst)
        chg_en |-> conv_en);
    assert_tgt_trk_R7: assert property (@(posedge clk) disable iff (rst)
        trk_stat |-> (chg_tgt_ma == TRK_TGT));
    assert_tgt_fast_R7: assert property (@(posedge clk) disable iff (rst)
        !trk_stat |-> (chg_tgt_ma == ichg_reg));
    assert_mode_off_R8: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_OFF) |-> !conv_en);
    assert_vmax_rst_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !$past(wr_en)) |-> (vmax_reg == VMAX_DEF));
    assert_ichg_keep_R7: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(ichg_reg));
endmodule

// File: tb/chg_mode_sup_tb_top.sv
module chg_mode_sup_tb_top;
    localparam int FL = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_en = 1'b0;
    logic [15:0] adp_mv = '0, sup_mv = '0, bat_mv = '0, wr_data = '0;
    logic [7:0]  die_degc = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;

    logic        adp_prsnt, adp_sel, conv_en, chg_en, trk_stat, trk_n, iso_reg;
    logic [1:0]  mode;
    logic [15:0] chg_tgt_ma, ichg_reg, vmax_reg;
    logic        p3, s3, c3, g3, t3, n3, i3;
    logic [1:0]  m3;
    logic [15:0] tg3, ic3, vmax3;

    always #2 clk = ~clk;

    chg_mode_sup #(.CELLS(2), .FILT_LEN(FL)) dut_i (
        .clk(clk), .rst(rst), .smp_en(smp_en), .adp_mv(adp_mv), .sup_mv(sup_mv),
        .bat_mv(bat_mv), .die_degc(die_degc), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .adp_prsnt(adp_prsnt), .adp_sel(adp_sel),
        .conv_en(conv_en), .chg_en(chg_en), .trk_stat(trk_stat), .trk_n(trk_n),
        .mode(mode), .chg_tgt_ma(chg_tgt_ma), .ichg_reg(ichg_reg),
        .vmax_reg(vmax_reg), .iso_reg(iso_reg)
    );

    chg_mode_sup #(.CELLS(3), .FILT_LEN(FL)) dut3_i (
        .clk(clk), .rst(rst), .smp_en(1'b0), .adp_mv(adp_mv), .sup_mv(sup_mv),
        .bat_mv(bat_mv), .die_degc(die_degc), .wr_en(1'b0), .wr_sel(wr_sel),
        .wr_data(wr_data), .adp_prsnt(p3), .adp_sel(s3), .conv_en(c3),
        .chg_en(g3), .trk_stat(t3), .trk_n(n3), .mode(m3), .chg_tgt_ma(tg3),
        .ichg_reg(ic3), .vmax_reg(vmax3), .iso_reg(i3)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // reference model state
    bit e_adp = 0, e_ot = 0, e_sup = 0, e_trk = 0, e_iso = 0;
    int e_cnt = 0, e_ichg = 0, e_vmin = 6000, e_vmax = 8400;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic check_all();
        int e_conv, e_mode;
        e_conv = (e_adp && !e_ot) ? 1 : 0;
        e_mode = (e_conv == 0) ? 0 : (e_trk ? 1 : 2);
        chk("R2", "adp_prsnt", int'(adp_prsnt), int'(e_adp));
        chk("R3", "adp_sel", int'(adp_sel), (e_adp && e_sup && !e_iso) ? 1 : 0);
        chk("R4_R5", "conv_en", int'(conv_en), e_conv);
        chk("R5", "chg_en", int'(chg_en), (e_conv == 1 && e_ichg != 0) ? 1 : 0);
        chk("R6_R8", "trk_stat", int'(trk_stat), int'(e_trk));
        chk("R8", "trk_n", int'(trk_n), e_trk ? 0 : 1);
        chk("R8", "mode", int'(mode), e_mode);
        chk("R7", "chg_tgt_ma", int'(chg_tgt_ma), e_trk ? 256 : e_ichg);
        chk("R7_R10", "ichg_reg", int'(ichg_reg), e_ichg);
        chk("R10", "vmax_reg", int'(vmax_reg), e_vmax);
        chk("R10", "iso_reg", int'(iso_reg), int'(e_iso));
    endtask

    // one cycle; inputs set just after a falling edge, results checked at the next one
    task automatic step(input bit en, input int a, input int s, input int b, input int t);
        bit raw;
        smp_en = en; adp_mv = 16'(a); sup_mv = 16'(s); bat_mv = 16'(b); die_degc = 8'(t);
        wr_en = 1'b0;
        @(negedge clk);
        if (en) begin
            if (a > 3200) e_adp = 1; else if (a < 3143) e_adp = 0;
            e_sup = (s > 4500);
            if (t > 150) e_ot = 1; else if (t < 125) e_ot = 0;
            raw = (b < e_vmin);
            if (raw != e_trk) begin
                e_cnt++;
                if (e_cnt == FL) begin e_trk = raw; e_cnt = 0; end
            end else e_cnt = 0;
        end
        check_all();
    endtask

    task automatic wr(input int sel, input int data);
        smp_en = 1'b0; wr_en = 1'b1; wr_sel = 2'(sel); wr_data = 16'(data);
        @(negedge clk);
        wr_en = 1'b0;
        case (sel)
            0: e_ichg = data;
            1: e_vmin = data;
            2: e_vmax = data;
            default: e_iso = data[0];
        endcase
        check_all();
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int lcg;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state, R9 default for both cell counts
        check_all();
        chk("R1", "mode", int'(mode), 0);
        chk("R9", "vmax 2-cell", int'(vmax_reg), 8400);
        chk("R9", "vmax 3-cell", int'(vmax3), 12600);
        chk("R1", "trk_n", int'(trk_n), 1);

        wr(0, 1500);
        // R2: sweep up then down across both adapter thresholds
        for (int v = 3100; v <= 3260; v++) step(1, v, 5000, 8000, 25);
        for (int v = 3260; v >= 3100; v--) step(1, v, 5000, 8000, 25);
        step(1, 3300, 5000, 8000, 25);
        // R3: supply threshold and isolate bit
        for (int s = 4495; s <= 4505; s++) step(1, 3300, s, 8000, 25);
        wr(3, 1);
        step(1, 3300, 5000, 8000, 25);
        wr(3, 0);
        // R4: thermal sweep up and down
        for (int t = 110; t <= 170; t++) step(1, 3300, 5000, 8000, t);
        for (int t = 170; t >= 110; t--) step(1, 3300, 5000, 8000, t);
        // R5: zero charge current drops charge enable
        wr(0, 0);
        step(1, 3300, 5000, 8000, 25);
        wr(0, 2000);
        // R6/R7: 0 V battery enters trickle, target override
        for (int k = 0; k < 5; k++) step(1, 3300, 5000, 0, 25);
        wr(0, 1800);
        step(1, 3300, 5000, 0, 25);
        // R6: broken run then complete run out of trickle
        step(1, 3300, 5000, 6000, 25);
        step(1, 3300, 5000, 6000, 25);
        step(1, 3300, 5000, 5999, 25);
        for (int k = 0; k < 4; k++) step(1, 3300, 5000, 6000, 25);
        // R10: new minimum and maximum
        wr(1, 7000);
        wr(2, 9000);
        // R11: idle cycles with wild inputs
        for (int k = 0; k < 20; k++) step(0, k * 911, k * 77, k * 13, k * 9);
        // R6: pseudo-random walk around the minimum, with idle cycles and 0 V
        lcg = 12345;
        for (int k = 0; k < 600; k++) begin
            int b;
            lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
            b = 6997 + ((lcg >> 8) % 6);
            if (((lcg >> 4) % 17) == 0) b = 0;
            step(((lcg >> 12) % 5) != 0, ((lcg >> 16) % 7 == 0) ? 3000 : 3300,
                 5000, b, ((lcg >> 20) % 11 == 0) ? 160 : 40);
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule